// File: doc/BRIEF.md
# Accumulator Add-With-Carry Unit

This block performs one add-with-carry step of a fixed-point signal-processing datapath. A 48-bit long word, taken from either the X or the Y input register, is widened to 56 bits by copying its sign bit. The widened word and the current carry flag are added to one of two 56-bit accumulators, A or B. The sum is written back into the chosen accumulator.

The same step refreshes a seven-bit flag set:

- **C** is the carry out of the top bit.
- **V** marks signed overflow.
- **L** is a limit flag that stays set once it is set.
- **N** is the sign of the result.
- **Z** marks a zero result.
- **E** and **U** report, under the current scaling mode, whether the integer (extension) part of the result is in use and whether the result is unnormalized.

Chaining several operations gives multi-word arithmetic, because each step consumes the carry left by the one before.

The block is driven by a plain one-cycle `start` strobe and answers with a one-cycle `done` pulse. There is no data stream at its edge and no back-pressure: operands are sampled when a strobe is accepted, and a strobe that arrives while an operation is in flight is dropped.

Top module: `acc_adc_unit`

## Requirements
- R1: While `rst_n` is low, both accumulators read zero, all seven flags read zero and `done` is low.
- R2: The select code `op_sel` chooses the operands as follows:
  - 00: X is added into A.
  - 01: X is added into B.
  - 10: Y is added into A.
  - 11: Y is added into B.

  The accumulator that was not chosen never changes.
- R3: The new value of the chosen accumulator is its old value, plus the chosen 48-bit word sign-extended from bit 47, plus the carry flag, modulo 2^56.
- R4: `flag_c` is set exactly when the unsigned 56-bit addition produces a carry out of bit 55.
- R5: `flag_n` equals bit 55 of the result. `flag_z` is set exactly when all 56 result bits are zero.
- R6: `flag_v` is set exactly when the signed 56-bit sum lies outside the 56-bit two's-complement range. `flag_l` becomes set whenever `flag_v` is set, and is never cleared by an operation.
- R7: `flag_e` is set when result bits 55 down to a low bound are not all equal. The low bound depends on `scale_mode`:
  - 00 (no scaling): bit 47.
  - 01 (scale down): bit 48.
  - 10 (scale up): bit 46.
  - 11: treated as no scaling.
- R8: `flag_u` is set when two result bits are equal. Which two depends on `scale_mode`, with the same mode codes as R7:
  - no scaling: bits 47 and 46.
  - scale down: bits 48 and 47.
  - scale up: bits 46 and 45.
- R9: Timing of an accepted strobe:
  - A strobe is accepted on the clock edge where `start` is high and no operation is in flight; that edge also captures `op_sel`, the selected word and `scale_mode`.
  - The result and all flags change together on the next edge, and `done` is high for exactly the one cycle after that edge.
  - At any other time the accumulators hold their values.
- R10: A strobe on the edge that completes an operation is ignored, so a new operation can be accepted at the earliest two edges after the previous one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Strobe that requests one add-with-carry step |
| op_sel | input | 2 | Source and destination select code (R2) |
| x_word | input | 48 | X source register |
| y_word | input | 48 | Y source register |
| scale_mode | input | 2 | 00 none, 01 scale down, 10 scale up, 11 none |
| acc_a | output | 56 | Accumulator A |
| acc_b | output | 56 | Accumulator B |
| flag_l | output | 1 | Sticky limit flag |
| flag_e | output | 1 | Extension in use |
| flag_u | output | 1 | Result unnormalized |
| flag_n | output | 1 | Result negative |
| flag_z | output | 1 | Result zero |
| flag_v | output | 1 | Signed overflow |
| flag_c | output | 1 | Carry out of bit 55 |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bound assertions check the properties that hold on every cycle:
- `done` is a single-cycle pulse that follows an accepted strobe by exactly two edges.
- A strobe is never accepted while an operation is in flight.
- Both accumulators never change on the same edge, and neither changes outside a completion.
- The limit flag never drops, a set overflow flag implies a set limit flag, and zero never coexists with negative.

The arithmetic is covered only by the bench's reference model, compared against the outputs every clock. That comparison covers the sum with sign extension and carry-in, the carry and overflow conditions, and the E and U windows in each scaling mode. The bench's scenarios drive the long overflow run, the carry-chain into zero, the select mapping and the dropped strobe.

// File: rtl/acc_adc_pkg.sv
package acc_adc_pkg;
  // Scaling mode code driven on scale_mode
  typedef enum logic [1:0] {
    SCL_NONE = 2'b00,
    SCL_DOWN = 2'b01,
    SCL_UP   = 2'b10,
    SCL_RSVD = 2'b11
  } scale_e;

  // Condition flag set kept by the unit
  typedef struct packed {
    logic l;
    logic e;
    logic u;
    logic n;
    logic z;
    logic v;
    logic c;
  } ccr_t;

  // Select-code fields: bit 0 picks the destination, bit 1 the source
  localparam int SEL_DST_BIT = 0;
  localparam int SEL_SRC_BIT = 1;
endpackage

// File: rtl/acc_adc_ctrl.sv
module acc_adc_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic accept,
  output logic busy,
  output logic done
);
  // One cycle of capture, one cycle of writeback
  assign accept = start && !busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      done <= 1'b0;
    end else begin
      busy <= accept;
      done <= busy;
    end
  end
endmodule

// File: rtl/acc_adc_alu.sv
module acc_adc_alu #(
  parameter int ACC_W = 56,
  parameter int SRC_W = 48
) (
  input  logic [ACC_W-1:0] dst,
  input  logic [SRC_W-1:0] src,
  input  logic             cin,
  output logic [ACC_W-1:0] sum,
  output logic             cout,
  output logic             ovf
);
  localparam int EXT_W = ACC_W - SRC_W;

  logic [ACC_W-1:0] src_ext;
  logic [ACC_W:0]   wide;

  generate
    if (EXT_W > 0) begin : g_ext
      assign src_ext = {{EXT_W{src[SRC_W-1]}}, src};
    end else begin : g_noext
      assign src_ext = src[ACC_W-1:0];
    end
  endgenerate

  assign wide = {1'b0, dst} + {1'b0, src_ext} + {{ACC_W{1'b0}}, cin};
  assign sum  = wide[ACC_W-1:0];
  assign cout = wide[ACC_W];
  // Signed overflow: like-signed operands give an unlike-signed sum
  assign ovf  = (dst[ACC_W-1] == src_ext[ACC_W-1]) &&
                (sum[ACC_W-1] != dst[ACC_W-1]);
endmodule

// File: rtl/acc_adc_flags.sv
module acc_adc_flags
  import acc_adc_pkg::*;
#(
  parameter int ACC_W = 56,
  parameter int SRC_W = 48
) (
  input  logic [ACC_W-1:0] res,
  input  scale_e           scale,
  output logic             ext_used,
  output logic             unnorm,
  output logic             neg,
  output logic             zero
);
  // Window index 0: scale up, 1: none, 2: scale down
  localparam int NWIN = 3;

  logic [NWIN-1:0] e_win;
  logic [NWIN-1:0] u_win;

  generate
    for (genvar g = 0; g < NWIN; g++) begin : g_win
      localparam int LO = SRC_W - 2 + g;
      assign e_win[g] = !((&res[ACC_W-1:LO]) || !(|res[ACC_W-1:LO]));
      assign u_win[g] = (res[LO] == res[LO-1]);
    end
  endgenerate

  always_comb begin
    unique case (scale)
      SCL_UP:   begin ext_used = e_win[0]; unnorm = u_win[0]; end
      SCL_DOWN: begin ext_used = e_win[2]; unnorm = u_win[2]; end
      default:  begin ext_used = e_win[1]; unnorm = u_win[1]; end
    endcase
  end

  assign neg  = res[ACC_W-1];
  assign zero = (res == '0);
endmodule

// File: rtl/acc_adc_unit.sv
module acc_adc_unit
  import acc_adc_pkg::*;
#(
  parameter int ACC_W = 56,
  parameter int SRC_W = 48
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [1:0]       op_sel,
  input  logic [SRC_W-1:0] x_word,
  input  logic [SRC_W-1:0] y_word,
  input  logic [1:0]       scale_mode,
  output logic [ACC_W-1:0] acc_a,
  output logic [ACC_W-1:0] acc_b,
  output logic             flag_l,
  output logic             flag_e,
  output logic             flag_u,
  output logic             flag_n,
  output logic             flag_z,
  output logic             flag_v,
  output logic             flag_c,
  output logic             done
);
  logic             accept;
  logic             busy;
  logic             dst_b_q;
  logic [SRC_W-1:0] src_q;
  scale_e           scale_q;
  ccr_t             ccr;
  ccr_t             ccr_nxt;
  logic [ACC_W-1:0] dst_val;
  logic [ACC_W-1:0] sum;
  logic             cout;
  logic             ovf;
  logic             e_w;
  logic             u_w;
  logic             n_w;
  logic             z_w;

  acc_adc_ctrl u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .accept (accept),
    .busy   (busy),
    .done   (done)
  );

  // Operand capture on the accepting edge
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dst_b_q <= 1'b0;
      src_q   <= '0;
      scale_q <= SCL_NONE;
    end else if (accept) begin
      dst_b_q <= op_sel[SEL_DST_BIT];
      src_q   <= op_sel[SEL_SRC_BIT] ? y_word : x_word;
      scale_q <= scale_e'(scale_mode);
    end
  end

  assign dst_val = dst_b_q ? acc_b : acc_a;

  acc_adc_alu #(.ACC_W(ACC_W), .SRC_W(SRC_W)) u_alu (
    .dst  (dst_val),
    .src  (src_q),
    .cin  (ccr.c),
    .sum  (sum),
    .cout (cout),
    .ovf  (ovf)
  );

  acc_adc_flags #(.ACC_W(ACC_W), .SRC_W(SRC_W)) u_flags (
    .res      (sum),
    .scale    (scale_q),
    .ext_used (e_w),
    .unnorm   (u_w),
    .neg      (n_w),
    .zero     (z_w)
  );

  always_comb begin
    ccr_nxt   = ccr;
    ccr_nxt.c = cout;
    ccr_nxt.v = ovf;
    ccr_nxt.n = n_w;
    ccr_nxt.z = z_w;
    ccr_nxt.e = e_w;
    ccr_nxt.u = u_w;
    ccr_nxt.l = ccr.l | ovf;
  end

  // Writeback of result and flags together
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_a <= '0;
      acc_b <= '0;
      ccr   <= '0;
    end else if (busy) begin
      if (dst_b_q) acc_b <= sum;
      else         acc_a <= sum;
      ccr <= ccr_nxt;
    end
  end

  assign flag_l = ccr.l;
  assign flag_e = ccr.e;
  assign flag_u = ccr.u;
  assign flag_n = ccr.n;
  assign flag_z = ccr.z;
  assign flag_v = ccr.v;
  assign flag_c = ccr.c;
endmodule

// File: rtl/acc_adc_chk.sv
module acc_adc_chk #(
  parameter int ACC_W = 56
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             busy,
  input logic             done,
  input logic [ACC_W-1:0] acc_a,
  input logic [ACC_W-1:0] acc_b,
  input logic             flag_l,
  input logic             flag_n,
  input logic             flag_z,
  input logic             flag_v
);
  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R9
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

  // R9
  busy_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> done);

  // R10
  no_reaccept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !busy);

  // R9
  acc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(acc_a) && $stable(acc_b)));

  // R2
  one_acc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !((acc_a != $past(acc_a)) && (acc_b != $past(acc_b))));

  // R6
  l_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flag_l |=> flag_l);

  // R6
  v_sets_l_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flag_v |-> flag_l);

  // R5
  z_not_n_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flag_z |-> !flag_n);
endmodule

bind acc_adc_unit acc_adc_chk #(.ACC_W(ACC_W)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .start  (start),
  .busy   (busy),
  .done   (done),
  .acc_a  (acc_a),
  .acc_b  (acc_b),
  .flag_l (flag_l),
  .flag_n (flag_n),
  .flag_z (flag_z),
  .flag_v (flag_v)
);

// File: tb/sim_acc_adc_unit.sv
`timescale 1ns/1ps
module sim_acc_adc_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  op_sel = 2'b00;
  logic [47:0] x_word = '0;
  logic [47:0] y_word = '0;
  logic [1:0]  scale_mode = 2'b00;
  logic [55:0] acc_a, acc_b;
  logic fl, fe, fu, fn, fz, fv, fc, done;

  acc_adc_unit u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .op_sel(op_sel),
    .x_word(x_word), .y_word(y_word), .scale_mode(scale_mode),
    .acc_a(acc_a), .acc_b(acc_b), .flag_l(fl), .flag_e(fe), .flag_u(fu),
    .flag_n(fn), .flag_z(fz), .flag_v(fv), .flag_c(fc), .done(done)
  );

  always #2.5 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit cmp_en = 0;

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Reference model state
  logic [55:0] ma = '0, mb = '0;
  logic ml = 0, me = 0, mu = 0, mn = 0, mz = 0, mv = 0, mc = 0, mdone = 0;
  bit          pend = 0;
  logic [1:0]  p_sel = '0, p_scale = '0;
  logic [47:0] p_src = '0;

  task automatic model_step(input logic [55:0] d, input logic [47:0] s,
                            input logic [1:0] scl, output logic [55:0] r);
    longint ds, ss, ex, hi, lo;
    logic [63:0] us;
    int lb;
    bit alleq;
    ds = longint'($signed(d));
    ss = longint'($signed(s));
    ex = ds + ss + longint'(mc);
    hi = (longint'(1) <<< 55) - 1;
    lo = -(longint'(1) <<< 55);
    r  = ex[55:0];
    us = {8'h00, d} + {8'h00, ss[55:0]} + {63'd0, mc};
    mc = us[56];
    mv = (ex > hi) || (ex < lo);
    ml = ml | mv;
    mn = r[55];
    mz = (r == 56'd0);
    case (scl)
      2'b01:   lb = 48;
      2'b10:   lb = 46;
      default: lb = 47;
    endcase
    alleq = 1;
    for (int i = lb; i <= 55; i++) if (r[i] != r[55]) alleq = 0;
    me = !alleq;
    mu = (r[lb] == r[lb-1]);
  endtask

  always @(posedge clk) begin
    logic [55:0] r;
    if (!rst_n) begin
      ma = '0; mb = '0; {ml, me, mu, mn, mz, mv, mc, mdone} = '0; pend = 0;
    end else begin
      mdone = 0;
      if (pend) begin
        model_step(p_sel[0] ? mb : ma, p_src, p_scale, r);
        if (p_sel[0]) mb = r; else ma = r;
        mdone = 1;
        pend  = 0;
      end else if (start) begin
        p_sel   = op_sel;
        p_src   = op_sel[1] ? y_word : x_word;
        p_scale = scale_mode;
        pend    = 1;
      end
    end
  end

  always @(negedge clk) begin
    if (cmp_en) begin
      chk("R3", "acc_a", {8'h0, acc_a}, {8'h0, ma});
      chk("R3", "acc_b", {8'h0, acc_b}, {8'h0, mb});
      chk("R9", "done", {63'd0, done}, {63'd0, mdone});
      chk("R4", "flag_c", {63'd0, fc}, {63'd0, mc});
      chk("R5", "flag_n", {63'd0, fn}, {63'd0, mn});
      chk("R5", "flag_z", {63'd0, fz}, {63'd0, mz});
      chk("R6", "flag_v", {63'd0, fv}, {63'd0, mv});
      chk("R6", "flag_l", {63'd0, fl}, {63'd0, ml});
      chk("R7", "flag_e", {63'd0, fe}, {63'd0, me});
      chk("R8", "flag_u", {63'd0, fu}, {63'd0, mu});
    end
  end

  task automatic op(input logic [1:0] s, input logic [47:0] x,
                    input logic [47:0] y, input logic [1:0] scl);
    @(negedge clk);
    op_sel = s; x_word = x; y_word = y; scale_mode = scl; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL R9 watchdog actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int ndone;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "acc_a", {8'h0, acc_a}, 64'd0);
    chk("R1", "acc_b", {8'h0, acc_b}, 64'd0);
    chk("R1", "flags", {57'd0, fl, fe, fu, fn, fz, fv, fc}, 64'd0);
    chk("R1", "done", {63'd0, done}, 64'd0);
    rst_n = 1'b1;
    cmp_en = 1;

    // R2 select mapping
    op(2'b01, 48'd5, 48'd99, 2'b00);
    chk("R2", "X into B", {8'h0, acc_b}, 64'd5);
    chk("R2", "A untouched", {8'h0, acc_a}, 64'd0);
    op(2'b10, 48'd77, 48'd3, 2'b00);
    chk("R2", "Y into A", {8'h0, acc_a}, 64'd3);
    op(2'b00, 48'd2, 48'd50, 2'b00);
    chk("R2", "X into A", {8'h0, acc_a}, 64'd5);
    op(2'b11, 48'd60, 48'd7, 2'b00);
    chk("R2", "Y into B", {8'h0, acc_b}, 64'd12);
    chk("R2", "A untouched", {8'h0, acc_a}, 64'd5);

    // R4/R5 carry out into zero: 5 + (-5)
    op(2'b00, 48'hFFFF_FFFF_FFFB, 48'd0, 2'b00);
    chk("R5", "zero result", {63'd0, fz}, 64'd1);
    chk("R4", "carry out", {63'd0, fc}, 64'd1);
    // R3 carry feeds next sum: 0 + 1 + 1
    op(2'b00, 48'd1, 48'd0, 2'b00);
    chk("R3", "carry-in used", {8'h0, acc_a}, 64'd2);

    // R6 drive B to overflow
    for (int i = 0; i < 300; i++) op(2'b01, 48'h7FFF_FFFF_FFFF, 48'd0, 2'(i % 3));
    chk("R6", "limit set", {63'd0, fl}, 64'd1);
    op(2'b00, 48'd1, 48'd0, 2'b00);
    chk("R6", "limit sticky", {63'd0, fl}, 64'd1);
    chk("R6", "no overflow", {63'd0, fv}, 64'd0);

    // R7/R8 random stimulus across all scale modes
    for (int i = 0; i < 400; i++) begin
      logic [63:0] rx, ry;
      rx = {$urandom, $urandom};
      ry = {$urandom, $urandom};
      op(2'($urandom), rx[47:0], ry[47:0], 2'($urandom));
    end

    // R10 strobe during busy ignored
    @(negedge clk);
    op_sel = 2'b00; x_word = 48'd1; start = 1'b1;
    @(negedge clk);
    x_word = 48'd100;
    @(negedge clk);
    start = 1'b0;
    ndone = done ? 1 : 0;
    repeat (4) begin
      @(negedge clk);
      if (done) ndone++;
    end
    chk("R10", "done count", 64'(ndone), 64'd1);

    cmp_en = 0;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule